// File: doc/BRIEF.md
# Overlap-Safe Block Copy Sequencer

This block copies a run of bytes from one 64 KiB bank of a 24-bit memory space to another, one byte at a time. It works through a synchronous single-port memory: each byte is one read followed by one write. A command supplies a source bank, a destination bank, a 16-bit source pointer (X), a 16-bit destination pointer (Y) and a 16-bit count. The count holds the number of bytes minus one. A direction bit selects ascending or descending stepping, so that source and destination regions may overlap without the copy corrupting itself.

Ascending mode (`dir_desc` = 0) is for a destination below an overlapping source. Both pointers start at the first byte and increment. Descending mode (`dir_desc` = 1) is for a destination above an overlapping source. Both pointers start at the last byte and decrement. The pointers wrap within 16 bits and never carry into the bank byte. The count decrements after every byte. The move finishes after the byte for which the count was zero, so the count ends at 0xFFFF.

The sequencer has four states: IDLE, SETUP, BYTE and FINISH.
- IDLE moves to SETUP when `start` is accepted.
- SETUP lasts two cycles and then moves to BYTE.
- BYTE runs a 7-phase loop once per byte. Phase 0 presents the read address. Phase 1 captures the read data. Phase 2 writes. Phase 3 steps X, Y and the count. Phases 4 to 6 pad the loop. At the end of phase 6, BYTE repeats if more bytes remain, or moves to FINISH after the last byte.
- FINISH lasts one cycle and returns to IDLE, raising `done` and updating the data bank output.

Top module: `blkmove_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0, and `reg_x`, `reg_y`, `reg_cnt` and `dbank_out` are 0.
- R2: A `start` sampled in IDLE latches all command inputs and raises `busy` on the next cycle. A `start` sampled while `busy` is 1 is ignored, and so are command input changes after acceptance.
- R3: For every byte, the block reads address {src_bank, X} and then writes the byte it read to address {dst_bank, Y}. `mem_we` is high for exactly one cycle per byte.
- R4: The count input is the byte count minus one. The count is decremented after each byte, and the move ends when it underflows, so count+1 bytes are moved and `reg_cnt` ends at 0xFFFF.
- R5: With `dir_desc` = 0, X and Y increment after each byte and end at their start values plus count+1.
- R6: With `dir_desc` = 1, X and Y decrement after each byte and end at their start values minus count+1.
- R7: X and Y wrap modulo 2^16. Address bits [23:16] always equal the bank operand and never receive a carry or borrow.
- R8: `busy` stays high for exactly 7*(count+1)+3 cycles.
- R9: `done` is a one-cycle pulse in the first cycle with `busy` low. From that cycle on, `dbank_out` holds the destination bank of the finished move.
- R10: A `start` presented in the cycle `done` is high is accepted as a new command.
- R11: Ascending mode with the destination below an overlapping source, and descending mode with the destination above it, both leave the destination holding the original source bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, accepted only in IDLE |
| dir_desc | input | 1 | 0 = ascending, 1 = descending |
| src_bank | input | 8 | Source bank operand |
| dst_bank | input | 8 | Destination bank operand |
| src_ptr | input | 16 | Initial X (source pointer) |
| dst_ptr | input | 16 | Initial Y (destination pointer) |
| count_in | input | 16 | Byte count minus one |
| mem_addr | output | 24 | Memory address {bank, pointer} |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_x | output | 16 | Current/final X |
| reg_y | output | 16 | Current/final Y |
| reg_cnt | output | 16 | Current/final count |
| dbank_out | output | 8 | Data bank after the last completed move |

## Verification
Two functions can meet in one cycle. The completion pulse can coincide with a new command request, and a start request can arrive while a move is running. The bench drives `start` in exactly the cycle it sees `done`. It judges the result by `busy` being high on the next cycle and by the second move's memory image, final registers and cycle count. It also pulses `start` with altered operands in the middle of moves. It judges those by the outcome matching the originally latched command.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_BYTE,
        ST_FINISH
    } mv_state_e;
endpackage

// File: rtl/blkmove_tick.sv
module blkmove_tick #(
    parameter int MAX = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  en,
    output logic [((MAX > 1) ? $clog2(MAX) : 1)-1:0] val,
    output logic                                  wrap
);
    localparam int W = (MAX > 1) ? $clog2(MAX) : 1;

    assign wrap = (val == W'(MAX - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (en)
            val <= wrap ? '0 : val + W'(1);
    end

    // R8: a wrap returns the phase to zero, keeping each loop the same length
    p_tick_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && wrap) |=> (val == '0));
endmodule

// File: rtl/blkmove_regs.sv
module blkmove_regs #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          desc,
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] y_in,
    input  logic [AW-1:0] c_in,
    output logic [AW-1:0] x_q,
    output logic [AW-1:0] y_q,
    output logic [AW-1:0] c_q,
    output logic          c_zero
);
    assign c_zero = (c_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            c_q <= '0;
        end else if (load) begin
            x_q <= x_in;
            y_q <= y_in;
            c_q <= c_in;
        end else if (step) begin
            x_q <= desc ? x_q - AW'(1) : x_q + AW'(1);
            y_q <= desc ? y_q - AW'(1) : y_q + AW'(1);
            c_q <= c_q - AW'(1);
        end
    end

    p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (c_q == $past(c_q) - AW'(1)));
    p_ptr_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !desc) |=> (x_q == $past(x_q) + AW'(1)) && (y_q == $past(y_q) + AW'(1)));
    p_ptr_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && desc) |=> (x_q == $past(x_q) - AW'(1)) && (y_q == $past(y_q) - AW'(1)));
endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
    import blkmove_pkg::*;
#(
    parameter int AW       = 16,
    parameter int BW       = 8,
    parameter int DW       = 8,
    parameter int BYTE_CYC = 7,
    parameter int PRE_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_desc,
    input  logic [BW-1:0]    src_bank,
    input  logic [BW-1:0]    dst_bank,
    input  logic [AW-1:0]    src_ptr,
    input  logic [AW-1:0]    dst_ptr,
    input  logic [AW-1:0]    count_in,
    output logic [AW+BW-1:0] mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    reg_x,
    output logic [AW-1:0]    reg_y,
    output logic [AW-1:0]    reg_cnt,
    output logic [BW-1:0]    dbank_out
);
    localparam int PW = (BYTE_CYC > 1) ? $clog2(BYTE_CYC) : 1;
    localparam int SW = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;
    localparam logic [PW-1:0] PH_RD   = PW'(0);
    localparam logic [PW-1:0] PH_CAP  = PW'(1);
    localparam logic [PW-1:0] PH_WR   = PW'(2);
    localparam logic [PW-1:0] PH_STEP = PW'(3);

    mv_state_e       state_q, state_d;
    logic [BW-1:0]   sbank_q, dbank_cmd_q, dbank_q;
    logic            dir_q, last_q, done_q;
    logic [DW-1:0]   data_q;
    logic [PW-1:0]   phase;
    logic            phase_wrap;
    logic [SW-1:0]   setup_val;
    logic            setup_wrap;
    logic            accept, do_step, cnt_zero;

    assign accept  = (state_q == ST_IDLE) && start;
    assign do_step = (state_q == ST_BYTE) && (phase == PH_STEP);

    blkmove_tick #(.MAX(PRE_CYC)) u_setup_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != ST_SETUP),
        .en   (state_q == ST_SETUP),
        .val  (setup_val),
        .wrap (setup_wrap)
    );

    blkmove_tick #(.MAX(BYTE_CYC)) u_phase_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != ST_BYTE),
        .en   (state_q == ST_BYTE),
        .val  (phase),
        .wrap (phase_wrap)
    );

    blkmove_regs #(.AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (do_step),
        .desc  (dir_q),
        .x_in  (src_ptr),
        .y_in  (dst_ptr),
        .c_in  (count_in),
        .x_q   (reg_x),
        .y_q   (reg_y),
        .c_q   (reg_cnt),
        .c_zero(cnt_zero)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  if (setup_wrap) state_d = ST_BYTE;
            ST_BYTE:   if (phase_wrap && last_q) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            sbank_q     <= '0;
            dbank_cmd_q <= '0;
            dbank_q     <= '0;
            dir_q       <= 1'b0;
            last_q      <= 1'b0;
            done_q      <= 1'b0;
            data_q      <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FINISH);
            if (accept) begin
                sbank_q     <= src_bank;
                dbank_cmd_q <= dst_bank;
                dir_q       <= dir_desc;
                last_q      <= 1'b0;
            end
            if (state_q == ST_BYTE && phase == PH_CAP)
                data_q <= mem_rdata;
            if (do_step)
                last_q <= cnt_zero;
            if (state_q == ST_FINISH)
                dbank_q <= dbank_cmd_q;
        end
    end

    // outputs
    always_comb begin
        mem_addr  = {sbank_q, reg_x};
        mem_we    = 1'b0;
        mem_wdata = data_q;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  mem_addr = {sbank_q, reg_x};
            ST_BYTE: begin
                if (phase == PH_WR) begin
                    mem_addr = {dbank_cmd_q, reg_y};
                    mem_we   = 1'b1;
                end else begin
                    mem_addr = {sbank_q, reg_x};
                end
            end
            ST_FINISH: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign done      = done_q;
    assign dbank_out = dbank_q;

    p_ignore_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sbank_q) && $stable(dbank_cmd_q) && $stable(dir_q));
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    p_wdata_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == $past(mem_rdata)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    p_final_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (reg_cnt == {AW{1'b1}}));
endmodule

// File: tb/blkmove_seq_tb.sv
module blkmove_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEMSZ = 262144;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_desc = 1'b0;
    logic [7:0]  src_bank = '0, dst_bank = '0;
    logic [15:0] src_ptr = '0, dst_ptr = '0, count_in = '0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we, busy, done;
    logic [15:0] reg_x, reg_y, reg_cnt;
    logic [7:0]  dbank_out;

    logic [7:0] mem  [0:MEMSZ-1];
    logic [7:0] refm [0:MEMSZ-1];
    logic [7:0] snap [0:MEMSZ-1];

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkmove_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_desc(dir_desc),
        .src_bank(src_bank), .dst_bank(dst_bank), .src_ptr(src_ptr),
        .dst_ptr(dst_ptr), .count_in(count_in), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .busy(busy), .done(done), .reg_x(reg_x), .reg_y(reg_y),
        .reg_cnt(reg_cnt), .dbank_out(dbank_out)
    );

    function automatic int idx(input logic [7:0] b, input logic [15:0] p);
        return {b[1:0], p};
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[idx(mem_addr[23:16], mem_addr[15:0])] <= mem_wdata;
        mem_rdata <= mem[idx(mem_addr[23:16], mem_addr[15:0])];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            finish_run();
        end
    end

    // bench reference: sequential byte copy following the requirements
    function automatic void ref_move(input logic [7:0] sb, db, input bit d,
                                     input logic [15:0] x0, y0, c0,
                                     output logic [15:0] xf, yf);
        logic [15:0] x = x0, y = y0;
        for (int i = 0; i <= int'(c0); i++) begin
            refm[idx(db, y)] = refm[idx(sb, x)];
            x = d ? x - 16'd1 : x + 16'd1;
            y = d ? y - 16'd1 : y + 16'd1;
        end
        xf = x; yf = y;
    endfunction

    // caller is at a negedge; leaves at the negedge where done is seen
    task automatic do_move(input logic [7:0] sb, db, input bit d,
                           input logic [15:0] x0, y0, c0, input bit poke);
        logic [15:0] xf, yf;
        int bcyc = 0, wcnt = 0, guard = 0;
        for (int i = 0; i < MEMSZ; i++) snap[i] = mem[i];
        ref_move(sb, db, d, x0, y0, c0, xf, yf);
        src_bank = sb; dst_bank = db; dir_desc = d;
        src_ptr = x0; dst_ptr = y0; count_in = c0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(done == 1'b0, "R9 done one cycle", done, 0);
        // R2: operands change after acceptance must be ignored
        src_bank = 8'h03; dst_bank = 8'h03; dir_desc = ~d;
        src_ptr = 16'h5555; dst_ptr = 16'hAAAA; count_in = 16'h0001;
        while (!done) begin
            if (busy) bcyc++;
            if (mem_we) wcnt++;
            if (poke && bcyc == 9) start = 1'b1;
            else start = 1'b0;
            guard++;
            if (guard > 2000) break;
            @(negedge clk);
        end
        start = 1'b0;
        check(bcyc == 7 * (int'(c0) + 1) + 3, "R8 busy cycles", bcyc, 7 * (int'(c0) + 1) + 3);
        check(wcnt == int'(c0) + 1, "R3 write count", wcnt, int'(c0) + 1);
        check(reg_cnt == 16'hFFFF, "R4 final count", reg_cnt, 16'hFFFF);
        check(reg_x == xf, d ? "R6 final X" : "R5 final X", reg_x, xf);
        check(reg_y == yf, d ? "R6 final Y" : "R5 final Y", reg_y, yf);
        check(dbank_out == db, "R9 data bank", dbank_out, db);
        begin
            int bad = 0;
            for (int i = 0; i < MEMSZ; i++) if (mem[i] !== refm[i]) bad++;
            check(bad == 0, "R3 R7 memory image", bad, 0);
        end
    endtask

    initial begin
        logic [15:0] r;
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i] = 8'($urandom);
            refm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_we, "R1 reset controls", {busy, done, mem_we}, 0);
        check(reg_x == 0 && reg_y == 0 && reg_cnt == 0 && dbank_out == 0,
              "R1 reset registers", {reg_x, reg_y}, 0);

        // R11 ascending, destination below overlapping source
        do_move(8'd0, 8'd0, 1'b0, 16'h1000, 16'h0FF8, 16'd15, 1'b0);
        begin
            int bad = 0;
            for (int i = 0; i < 16; i++) if (mem[16'h0FF8 + i] !== snap[16'h1000 + i]) bad++;
            check(bad == 0, "R11 ascending overlap", bad, 0);
        end
        @(negedge clk);
        // R11 descending, destination above overlapping source
        do_move(8'd1, 8'd1, 1'b1, 16'h2010, 16'h2018, 16'd15, 1'b0);
        begin
            int bad = 0;
            for (int i = 0; i < 16; i++)
                if (mem[idx(8'd1, 16'h2018 - 16'(i))] !== snap[idx(8'd1, 16'h2010 - 16'(i))]) bad++;
            check(bad == 0, "R11 descending overlap", bad, 0);
        end
        @(negedge clk);
        // R7 wrap ascending, bank must not receive a carry
        do_move(8'd1, 8'd2, 1'b0, 16'hFFFD, 16'hFFFE, 16'd4, 1'b0);
        check(reg_x == 16'h0002, "R7 wrap X", reg_x, 16'h0002);
        @(negedge clk);
        // R7 wrap descending
        do_move(8'd3, 8'd0, 1'b1, 16'h0001, 16'h0000, 16'd3, 1'b0);
        check(reg_y == 16'hFFFC, "R7 wrap Y", reg_y, 16'hFFFC);
        @(negedge clk);
        // R4 single byte
        do_move(8'd2, 8'd3, 1'b0, 16'h4000, 16'h8000, 16'd0, 1'b0);
        @(negedge clk);
        // R2 start pulse while busy is ignored
        do_move(8'd0, 8'd2, 1'b1, 16'h3333, 16'h7777, 16'd6, 1'b1);
        // R10 start in the done cycle, no gap
        do_move(8'd2, 8'd1, 1'b0, 16'h1234, 16'h4321, 16'd5, 1'b0);
        do_move(8'd1, 8'd3, 1'b1, 16'h0100, 16'h0200, 16'd2, 1'b0);

        for (int t = 0; t < 20; t++) begin
            r = 16'($urandom_range(0, 40));
            if ($urandom_range(0, 1) == 0) @(negedge clk);
            do_move(8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), r,
                    1'($urandom_range(0, 3) == 0));
        end
        @(negedge clk);
        finish_run();
    end
endmodule